// File: doc/BRIEF.md
# Address Bus Tenure Controller

This block is the requesting side of a shared, arbitrated address bus. When the core has a transaction waiting, the controller raises a bus request and watches the central grant. It also watches the shared busy line and the transfer-start strobes of other masters. Once a grant arrives while the bus is free, the controller takes the bus. It drives its busy output and a one-cycle transfer-start pulse. It keeps the bus until the address acknowledge is sampled, and then lets go. After the busy output drops, the enable of the busy driver stays on for a set number of cycles and then falls. This stands in for a pad driver that goes to high impedance a little after the line is negated.

The controller keeps its own record of every foreign start-to-acknowledge window. Because of this, it never takes the bus inside such a window, even when another master leaves the shared busy line undriven. The core can withdraw a waiting transaction with an abort input, or by dropping the pending input, at any time before ownership. After ownership the tenure always runs to the acknowledge. A done pulse tells the core that the address tenure has finished.

Top module: `addr_tenure_ctrl`

## Requirements
- R1: While `rst` is sampled high, all outputs (`bus_req_o`, `busy_o`, `busy_oe_o`, `start_o`, `done_o`) are low in the following cycle. All signals are active-high.
- R2: In idle, `txn_pend_i` high with `txn_abort_i` low raises `bus_req_o` in the next cycle. `bus_req_o` stays high until ownership is taken or the transaction is withdrawn.
- R3: In the requesting state, a grant is accepted when four conditions hold in the same cycle: `bus_grant_i` is high, `busy_in_i` is low, the bus is not blocked by a foreign window, and the transaction is still wanted. In the next cycle `busy_o`, `busy_oe_o` and `start_o` are high and `bus_req_o` is low.
- R4: `start_o` is high for exactly one cycle, which is the first cycle of ownership.
- R5: A grant sampled together with `busy_in_i` high is refused. `busy_o` stays low and `bus_req_o` stays high.
- R6: A foreign window opens in the cycle `start_in_i` is sampled high while this master does not own the bus. It closes after `ack_i` is sampled. Every grant from the start cycle through the acknowledge cycle, inclusive, is refused.
- R7: If `txn_abort_i` is high, or `txn_pend_i` is low, while requesting, no ownership is taken even with a qualified grant. In the next cycle `busy_o` and `bus_req_o` are low.
- R8: `busy_o` stays high until `ack_i` is sampled high. It is low in the next cycle, and `done_o` pulses high in that same cycle.
- R9: `busy_oe_o` is high whenever `busy_o` is high. After `busy_o` falls, it stays high for `OE_HOLD` more cycles (default 1) and then goes low.
- R10: `txn_abort_i` has no effect while the bus is owned. `busy_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_pend_i | input | 1 | Core has an address transaction waiting |
| txn_abort_i | input | 1 | Core withdraws the waiting transaction |
| bus_grant_i | input | 1 | Grant from the central arbiter |
| busy_in_i | input | 1 | Shared busy line driven by another master |
| start_in_i | input | 1 | Transfer-start strobe seen from another master |
| ack_i | input | 1 | Address acknowledge |
| bus_req_o | output | 1 | Bus request to the arbiter |
| busy_o | output | 1 | Busy line value driven by this master |
| busy_oe_o | output | 1 | Output enable of the busy driver |
| start_o | output | 1 | Transfer-start pulse of this master |
| done_o | output | 1 | Address tenure finished |

## Verification
The grant cycle is swept over all sixteen combinations of grant, shared busy, foreign start and abort. This separates the single accepting pattern from refusals caused by the busy line, by a foreign start in the same cycle, and by a withdrawn transaction. Each refusal must leave the request in its own expected state. A separate sequence opens a foreign window, offers grants inside it, and includes the acknowledge cycle. It confirms that blocking ends exactly one cycle after the acknowledge. Accepted tenures are then held across several cycles with abort raised, to tell a correct hold from an early release, and the release and driver-enable fall are timed cycle by cycle.

// File: rtl/tenure_pkg.sv
package tenure_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_OWN  = 2'd2,
    ST_REL  = 2'd3
  } tenure_state_e;
endpackage

// File: rtl/tenure_window_watch.sv
// Tracks other masters' start-to-acknowledge windows.
module tenure_window_watch (
  input  logic clk,
  input  logic rst,
  input  logic start_in_i,
  input  logic ack_i,
  input  logic own_i,
  output logic blocked_o
);
  logic win_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= 1'b0;
    end else if (!own_i) begin
      if (start_in_i && !ack_i) win_q <= 1'b1;
      else if (ack_i)           win_q <= 1'b0;
    end
  end

  // the start cycle itself already blocks
  assign blocked_o = win_q | (start_in_i & ~own_i);

  // R6: an open window stays open until an acknowledge is seen
  p_window_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (win_q && !ack_i && !own_i) |=> blocked_o);
endmodule

// File: rtl/tenure_release_timer.sv
// Counts the cycles the busy driver stays enabled after negation.
module tenure_release_timer #(
  parameter int OE_HOLD = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int CW = $clog2(OE_HOLD + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                         cnt_q <= '0;
    else if (load_i)                 cnt_q <= CW'(OE_HOLD);
    else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q <= CW'(1));

  initial begin
    a_hold_positive_r9: assert (OE_HOLD >= 1);
  end
endmodule

// File: rtl/tenure_fsm.sv
// Four-state tenure machine with registered outputs.
module tenure_fsm
  import tenure_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          pend_i,
  input  logic          abort_i,
  input  logic          grant_i,
  input  logic          busy_in_i,
  input  logic          blocked_i,
  input  logic          ack_i,
  input  logic          rel_expired_i,
  output tenure_state_e state_o,
  output logic          bus_req_o,
  output logic          busy_o,
  output logic          busy_oe_o,
  output logic          start_o,
  output logic          done_o,
  output logic          rel_load_o,
  output logic          rel_tick_o
);
  tenure_state_e state_q;
  logic          want;
  logic          qual;

  assign want = pend_i & ~abort_i;
  assign qual = grant_i & ~busy_in_i & ~blocked_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      bus_req_o <= 1'b0;
      busy_o    <= 1'b0;
      busy_oe_o <= 1'b0;
      start_o   <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      start_o <= 1'b0;
      done_o  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (want) begin
            state_q   <= ST_REQ;
            bus_req_o <= 1'b1;
          end
        end
        ST_REQ: begin
          if (!want) begin
            state_q   <= ST_IDLE;
            bus_req_o <= 1'b0;
          end else if (qual) begin
            state_q   <= ST_OWN;
            bus_req_o <= 1'b0;
            busy_o    <= 1'b1;
            busy_oe_o <= 1'b1;
            start_o   <= 1'b1;
          end
        end
        ST_OWN: begin
          if (ack_i) begin
            state_q <= ST_REL;
            busy_o  <= 1'b0;
            done_o  <= 1'b1;
          end
        end
        ST_REL: begin
          if (rel_expired_i) begin
            state_q   <= ST_IDLE;
            busy_oe_o <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o    = state_q;
  assign rel_load_o = (state_q == ST_OWN) & ack_i;
  assign rel_tick_o = (state_q == ST_REL);

  // R1: reset clears the outputs
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!bus_req_o && !busy_o && !busy_oe_o && !start_o && !done_o));
  // R3: ownership only follows a free, granted cycle
  p_accept_qualified_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(grant_i && !busy_in_i && !blocked_i && pend_i && !abort_i));
  // R4: start strobe lasts one cycle
  p_start_single_r4: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);
  // R5: shared busy blocks ownership
  p_busy_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_in_i && !busy_o) |=> !busy_o);
  // R8: busy held until acknowledge, released after it
  p_hold_until_ack_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !ack_i) |=> busy_o);
  p_release_after_ack_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && ack_i) |=> (!busy_o && done_o));
  // R9: driver enabled whenever busy is driven
  p_oe_covers_r9: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> busy_oe_o);
endmodule

// File: rtl/addr_tenure_ctrl.sv
module addr_tenure_ctrl
  import tenure_pkg::*;
#(
  parameter int OE_HOLD = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic txn_pend_i,
  input  logic txn_abort_i,
  input  logic bus_grant_i,
  input  logic busy_in_i,
  input  logic start_in_i,
  input  logic ack_i,
  output logic bus_req_o,
  output logic busy_o,
  output logic busy_oe_o,
  output logic start_o,
  output logic done_o
);
  tenure_state_e state;
  logic          blocked;
  logic          rel_load;
  logic          rel_tick;
  logic          rel_expired;
  logic          owning;

  assign owning = (state == ST_OWN);

  tenure_window_watch u_watch (
    .clk        (clk),
    .rst        (rst),
    .start_in_i (start_in_i),
    .ack_i      (ack_i),
    .own_i      (owning),
    .blocked_o  (blocked)
  );

  tenure_release_timer #(.OE_HOLD(OE_HOLD)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load_i    (rel_load),
    .tick_i    (rel_tick),
    .expired_o (rel_expired)
  );

  tenure_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .pend_i        (txn_pend_i),
    .abort_i       (txn_abort_i),
    .grant_i       (bus_grant_i),
    .busy_in_i     (busy_in_i),
    .blocked_i     (blocked),
    .ack_i         (ack_i),
    .rel_expired_i (rel_expired),
    .state_o       (state),
    .bus_req_o     (bus_req_o),
    .busy_o        (busy_o),
    .busy_oe_o     (busy_oe_o),
    .start_o       (start_o),
    .done_o        (done_o),
    .rel_load_o    (rel_load),
    .rel_tick_o    (rel_tick)
  );

  // R6: no ownership begins inside a foreign window
  p_window_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    (blocked && !busy_o) |=> !busy_o);
  // R10: abort cannot cut an owned tenure short
  p_abort_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (busy_o && txn_abort_i && !ack_i) |=> busy_o);
  // R2: request is not dropped while still wanted and not granted
  p_req_held_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_req_o && txn_pend_i && !txn_abort_i && !bus_grant_i) |=> bus_req_o);
endmodule

// File: tb/addr_tenure_ctrl_bench.sv
`timescale 1ns/1ps
module addr_tenure_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txn_pend_i = 1'b0, txn_abort_i = 1'b0, bus_grant_i = 1'b0;
  logic busy_in_i = 1'b0, start_in_i = 1'b0, ack_i = 1'b0;
  logic bus_req_o, busy_o, busy_oe_o, start_o, done_o;
  logic [4:0] obs;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  addr_tenure_ctrl u_addr_tenure_ctrl (
    .clk(clk), .rst(rst), .txn_pend_i(txn_pend_i), .txn_abort_i(txn_abort_i),
    .bus_grant_i(bus_grant_i), .busy_in_i(busy_in_i), .start_in_i(start_in_i),
    .ack_i(ack_i), .bus_req_o(bus_req_o), .busy_o(busy_o), .busy_oe_o(busy_oe_o),
    .start_o(start_o), .done_o(done_o)
  );

  // order: req, busy, oe, start, done
  assign obs = {bus_req_o, busy_o, busy_oe_o, start_o, done_o};

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [4:0] exp);
    checks++;
    if (obs !== exp) begin
      errors++;
      $display("FAIL %s: outputs %b expected %b at %0t", tag, obs, exp, $time);
    end
  endtask

  task automatic clear_inputs();
    txn_pend_i = 0; txn_abort_i = 0; bus_grant_i = 0;
    busy_in_i = 0; start_in_i = 0; ack_i = 0;
  endtask

  task automatic do_reset();
    clear_inputs();
    rst = 1;
    step();
    step();
    check("R1 reset", 5'b00000);
    rst = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // sweep the grant cycle: bit0 grant, bit1 busy_in, bit2 start_in, bit3 abort
    for (int c = 0; c < 16; c++) begin
      logic acc;
      do_reset();
      txn_pend_i = 1;
      step();
      check("R2 request raised", 5'b10000);
      bus_grant_i = c[0]; busy_in_i = c[1]; start_in_i = c[2]; txn_abort_i = c[3];
      acc = c[0] & ~c[1] & ~c[2] & ~c[3];
      step();
      if (acc)       check("R3 accept", 5'b01110);
      else if (c[3]) check("R7 aborted", 5'b00000);
      else           check("R5 R6 refused", 5'b10000);
      if (acc) begin
        bus_grant_i = 0; txn_abort_i = 1;
        step();
        check("R4 R10 start ends, abort ignored", 5'b01100);
        txn_abort_i = 0; ack_i = 1;
        step();
        check("R8 release with done", 5'b00101);
        ack_i = 0; txn_pend_i = 0;
        step();
        check("R9 enable drops", 5'b00000);
      end
    end

    // foreign window sequence
    do_reset();
    txn_pend_i = 1;
    step();
    check("R2 request raised", 5'b10000);
    start_in_i = 1;
    step();
    check("R6 start cycle", 5'b10000);
    start_in_i = 0; bus_grant_i = 1;
    for (int k = 0; k < 3; k++) begin
      step();
      check("R6 inside window", 5'b10000);
    end
    ack_i = 1;
    step();
    check("R6 ack cycle still blocked", 5'b10000);
    ack_i = 0;
    step();
    check("R3 accept after window", 5'b01110);
    bus_grant_i = 0;
    for (int k = 0; k < 3; k++) begin
      step();
      check("R8 held without ack", 5'b01100);
    end
    ack_i = 1;
    step();
    check("R8 release with done", 5'b00101);
    ack_i = 1;
    step();
    check("R9 enable drops", 5'b00000);
    ack_i = 0;
    step();
    check("R2 re-request", 5'b10000);
    txn_pend_i = 0;
    step();
    check("R7 pending dropped", 5'b00000);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule